// File: doc/BRIEF.md
# AXI4 Burst Read RAM Slave

This block serves AXI4 read bursts from a byte-addressed memory that it holds internally. A manager presents one burst request on the address-read channel. The block accepts it and returns one data beat per transfer on the read-data channel. It steps the beat address for fixed, incrementing and wrapping bursts, and it ends the burst with a last-beat flag. Only one burst is in flight at a time. The address channel stays closed until the final beat of the current burst has been taken.

Every beat carries the whole bus-width word that contains the current beat address. This holds even when the beat size is narrower than the bus. Bytes are packed little-endian, so the lowest address sits in the least significant byte lane. The memory index wraps modulo the memory size, so any address maps onto the array. A byte-wide write port fills the memory. This port stands for the write half of the same RAM, which shares the array. When the size field is not wired, a parameter makes the block treat every beat as full width.

Top module: `axi_rd_ram`

## Requirements
- R1: After reset, rvalid is low and arready is high.
- R2: An accepted burst with length field L yields exactly L+1 beats. rlast is high on the final beat only, and rvalid drops in the cycle after the final beat is accepted.
- R3: Every beat carries rid equal to the arid of its burst and rresp equal to 2'b00 (OKAY).
- R4: arready is low from the cycle after a request is accepted until the final beat has been accepted, and it is high again in the next cycle.
- R5: While rvalid is high and rready is low, rvalid, rdata, rid and rlast hold their values.
- R6: In an incrementing burst (arburst 2'b01), the first beat address is araddr rounded down to 2^arsize bytes. Each later beat adds 2^arsize bytes.
- R7: In a fixed burst (arburst 2'b00), every beat uses the same address.
- R8: In a wrapping burst (arburst 2'b10), the address wraps back to the lower boundary when it reaches the upper one. The lower boundary is araddr rounded down to 2^arsize*(L+1). The upper boundary is the lower boundary plus 2^arsize*(L+1).
- R9: Each beat returns the full word at the beat address rounded down to a multiple of DATA_W/8. The word index is taken modulo MEM_BYTES.
- R10: rdata bits [8i+7:8i] hold the memory byte at word base plus i.
- R11: With USE_ARSIZE set to 0, arsize is ignored and every beat is DATA_W/8 bytes.
- R12: A cycle with wr_en high stores wr_byte at wr_addr modulo MEM_BYTES. Later reads return the stored byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe from the shared write side |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_byte | input | 8 | Byte to store |
| arvalid | input | 1 | Read request valid |
| arready | output | 1 | Read request accepted |
| arid | input | ID_W | Burst identifier |
| araddr | input | ADDR_W | Start byte address |
| arlen | input | 8 | Beats minus one |
| arsize | input | 3 | Log2 of bytes per beat |
| arburst | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping |
| rvalid | output | 1 | Read beat valid |
| rready | input | 1 | Read beat accepted |
| rid | output | ID_W | Identifier echoed from the request |
| rdata | output | DATA_W | Full word, little-endian |
| rresp | output | 2 | Response, always OKAY |
| rlast | output | 1 | Final beat of the burst |

## Verification
A wrong beat address or boundary register shows up as a wrong rdata word at the ports. This happens in the first beat that follows the faulty step, and for wrapping bursts at the very beat where the wrap should occur. A wrong beat count moves rlast off the final beat and changes the cycle in which arready returns high. Both appear within one beat of the error. A data register that is reloaded while the manager stalls appears at the next stalled cycle. That cycle is checked against the expected word held from the previous one.

// File: rtl/axi_rd_ram.sv
module axi_rd_ram #(
  parameter int DATA_W     = 32,
  parameter int ID_W       = 4,
  parameter int ADDR_W     = 16,
  parameter int MEM_BYTES  = 256,
  parameter bit USE_ARSIZE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_byte,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ID_W-1:0]   arid,
  input  logic [ADDR_W-1:0] araddr,
  input  logic [7:0]        arlen,
  input  logic [2:0]        arsize,
  input  logic [1:0]        arburst,
  output logic              rvalid,
  input  logic              rready,
  output logic [ID_W-1:0]   rid,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rlast
);
  localparam int LANES   = DATA_W / 8;
  localparam int LANE_AW = $clog2(LANES);
  localparam int MEM_AW  = $clog2(MEM_BYTES);
  localparam logic [1:0] BT_FIXED = 2'b00;
  localparam logic [1:0] BT_WRAP  = 2'b10;

  logic [7:0] mem [MEM_BYTES];

  logic [ADDR_W-1:0] cur_q, lo_q, hi_q;
  logic [7:0]        len_q, cnt_q;
  logic [2:0]        sz_q;
  logic [1:0]        bt_q;

  logic [2:0]        ar_sz;
  logic [ADDR_W-1:0] ar_nb, ar_align, ar_tsz, ar_lo;
  logic [ADDR_W-1:0] nb_q, step, nxt;

  wire ar_fire = arvalid && arready;
  wire r_fire  = rvalid && rready;

  assign arready = !rvalid;
  assign rresp   = 2'b00;
  assign rlast   = (cnt_q == len_q);

  generate
    if (USE_ARSIZE) begin : g_sz_port
      assign ar_sz = arsize;
    end else begin : g_sz_full
      assign ar_sz = 3'(LANE_AW);
    end
  endgenerate

  assign ar_nb    = ADDR_W'(1) << ar_sz;
  assign ar_align = araddr & ~(ar_nb - ADDR_W'(1));
  assign ar_tsz   = ar_nb * (ADDR_W'(arlen) + ADDR_W'(1));
  assign ar_lo    = araddr & ~(ar_tsz - ADDR_W'(1));

  assign nb_q = ADDR_W'(1) << sz_q;
  assign step = cur_q + nb_q;
  assign nxt  = (bt_q == BT_FIXED) ? cur_q :
                ((bt_q == BT_WRAP) && (step == hi_q)) ? lo_q : step;

  function automatic logic [DATA_W-1:0] fetch(input logic [ADDR_W-1:0] a);
    logic [MEM_AW-1:0] base;
    logic [DATA_W-1:0] w;
    base = a[MEM_AW-1:0] & ~MEM_AW'(LANES - 1);
    for (int i = 0; i < LANES; i++)
      w[8*i +: 8] = mem[MEM_AW'(base + MEM_AW'(i))];
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr[MEM_AW-1:0]] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rid    <= '0;
      rdata  <= '0;
      cur_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
      sz_q   <= '0;
      bt_q   <= '0;
    end else if (ar_fire) begin
      rvalid <= 1'b1;
      rid    <= arid;
      len_q  <= arlen;
      cnt_q  <= '0;
      sz_q   <= ar_sz;
      bt_q   <= arburst;
      cur_q  <= ar_align;
      lo_q   <= ar_lo;
      hi_q   <= ar_lo + ar_tsz;
      rdata  <= fetch(ar_align);
    end else if (r_fire) begin
      if (rlast) begin
        rvalid <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 8'd1;
        cur_q <= nxt;
        rdata <= fetch(nxt);
      end
    end
  end

  // R5
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rid) && $stable(rlast));
  // R4
  ar_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire |=> rvalid && !arready);
  // R2
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_fire && rlast |=> !rvalid);
  // R2
  mid_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_fire && !rlast |=> rvalid);
  // R3
  id_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire |=> rid == $past(arid));
  // R6
  size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar_fire |-> ar_nb <= ADDR_W'(LANES));
endmodule

// File: tb/axi_rd_ram_test.sv
`timescale 1ns/1ps
module axi_rd_ram_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_byte = '0;
  logic arvalid = 1'b0, arready;
  logic [3:0]  arid = '0;
  logic [15:0] araddr = '0;
  logic [7:0]  arlen = '0;
  logic [2:0]  arsize = '0;
  logic [1:0]  arburst = '0;
  logic rvalid, rready = 1'b0, rlast;
  logic [3:0]  rid;
  logic [31:0] rdata;
  logic [1:0]  rresp;

  logic a2v = 1'b0, a2r;
  logic [3:0]  a2id = '0;
  logic [15:0] a2addr = '0;
  logic [7:0]  a2len = '0;
  logic [2:0]  a2sz = '0;
  logic [1:0]  a2bt = '0;
  logic r2v, r2ready = 1'b0, r2last;
  logic [3:0]  r2id;
  logic [31:0] r2data;
  logic [1:0]  r2resp;

  axi_rd_ram uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .arvalid(arvalid), .arready(arready), .arid(arid), .araddr(araddr), .arlen(arlen),
    .arsize(arsize), .arburst(arburst), .rvalid(rvalid), .rready(rready), .rid(rid),
    .rdata(rdata), .rresp(rresp), .rlast(rlast));

  axi_rd_ram #(.USE_ARSIZE(1'b0)) uut_fw (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .arvalid(a2v), .arready(a2r), .arid(a2id), .araddr(a2addr), .arlen(a2len),
    .arsize(a2sz), .arburst(a2bt), .rvalid(r2v), .rready(r2ready), .rid(r2id),
    .rdata(r2data), .rresp(r2resp), .rlast(r2last));

  int total = 0;
  int bad = 0;
  logic [7:0] ref_mem [256];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(input int a);
    logic [31:0] w;
    int base = (a / 4 * 4) % 256;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = ref_mem[(base + i) % 256];
    return w;
  endfunction

  task automatic burst(input logic [3:0] id, input int addr, input int len, input int size,
                       input logic [1:0] bt, input bit stall, input string dreq);
    logic [31:0] ed[$];
    logic [31:0] prev_d;
    bit prev_stall = 0;
    int nb = 1 << size;
    int a = addr / nb * nb;
    int ts = nb * (len + 1);
    int lo = addr / ts * ts;
    int k = 0;
    int cyc = 0;
    for (int n = 0; n <= len; n++) begin
      ed.push_back(word_at(a));
      if (bt != 2'b00) a += nb;
      if (bt == 2'b10 && a == lo + ts) a = lo;
    end
    @(negedge clk);
    arvalid = 1; arid = id; araddr = 16'(addr); arlen = 8'(len);
    arsize = 3'(size); arburst = bt;
    chk(arready == 1'b1, "R4", "arready idle", 32'(arready), 1);
    @(negedge clk);
    arvalid = 0;
    while (k <= len && cyc < 2000) begin
      chk(rvalid == 1'b1, "R2", "rvalid in burst", 32'(rvalid), 1);
      chk(rdata == ed[k], dreq, "rdata", rdata, ed[k]);
      chk(rid == id && rresp == 2'b00, "R3", "rid/rresp", {rid, 2'b0, rresp}, {id, 4'b0});
      chk(rlast == (k == len), "R2", "rlast", 32'(rlast), 32'(k == len));
      chk(arready == 1'b0, "R4", "arready busy", 32'(arready), 0);
      if (prev_stall) chk(rdata == prev_d, "R5", "held rdata", rdata, prev_d);
      rready = stall ? (cyc % 3 != 1) : 1'b1;
      prev_stall = !rready;
      prev_d = rdata;
      if (rready) k++;
      cyc++;
      @(negedge clk);
    end
    rready = 0;
    chk(rvalid == 1'b0, "R2", "no extra beat", 32'(rvalid), 0);
    chk(arready == 1'b1, "R4", "arready back", 32'(arready), 1);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R2 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(rvalid == 1'b0, "R1", "rvalid in reset", 32'(rvalid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(rvalid == 1'b0 && arready == 1'b1, "R1", "idle after reset",
        {rvalid, arready}, 32'b01);
    // R12 fill
    wr_en = 1;
    for (int i = 0; i < 256; i++) begin
      wr_addr = 16'(i); wr_byte = 8'((i * 7 + 3) & 8'hff);
      ref_mem[i] = wr_byte;
      @(negedge clk);
    end
    wr_en = 0;
    // R6 R10 incrementing full width
    burst(4'h3, 'h20, 3, 2, 2'b01, 0, "R10");
    // R6 narrow beats, full words returned, with stalls (R5)
    burst(4'h5, 'h41, 5, 0, 2'b01, 1, "R6");
    // R7 fixed
    burst(4'h7, 'h30, 2, 2, 2'b00, 1, "R7");
    // R8 wrapping
    burst(4'h8, 'h38, 3, 2, 2'b10, 0, "R8");
    burst(4'h9, 'h86, 7, 1, 2'b10, 1, "R8");
    // R9 index modulo memory size
    burst(4'hA, 'h1FC, 2, 2, 2'b01, 0, "R9");
    // R12 write with address beyond memory size
    @(negedge clk);
    wr_en = 1; wr_addr = 16'h0105; wr_byte = 8'hA5; ref_mem[5] = 8'hA5;
    @(negedge clk);
    wr_en = 0;
    burst(4'hB, 'h04, 0, 2, 2'b01, 0, "R12");
    // R11 full-width instance ignores arsize
    @(negedge clk);
    a2v = 1; a2id = 4'h9; a2addr = 16'h0011; a2len = 8'd1; a2sz = 3'd0; a2bt = 2'b01;
    @(negedge clk);
    a2v = 0; r2ready = 1;
    chk(r2v && r2data == word_at('h10) && !r2last, "R11", "beat0",
        r2data, word_at('h10));
    @(negedge clk);
    chk(r2v && r2data == word_at('h14) && r2last, "R11", "beat1",
        r2data, word_at('h14));
    chk(r2id == 4'h9, "R3", "rid full-width", 32'(r2id), 9);
    @(negedge clk);
    r2ready = 0;
    chk(r2v == 1'b0, "R11", "burst end", 32'(r2v), 0);
    finish_run();
  end
endmodule